// File: doc/BRIEF.md
# Successive Approximation Conversion Controller

This block is the digital side of a feedback analog-to-digital converter. It owns the trial code that feeds an external DAC and reads back one comparator bit, high when the held analog input lies above the DAC level. A single-cycle start request launches a binary search over the code. The search works from the most significant bit down to the least significant. Each bit is first set as a trial and then kept or dropped according to the comparator. The search always takes a fixed number of cycles, equal to the code width, whatever the input.

When the last bit is decided, the finished code is copied into a separate result register and a completion flag is raised. The trial code on the DAC port may then move during the next conversion without disturbing the reported value. The code width is a parameter from 4 to 16. The DAC, the comparator and the sample-and-hold sit outside the block.

Top module: `sar_conv_ctrl`

## Requirements
- R1: A synchronous active-high reset forces `dac_code`, `result`, `done` and `busy` to zero.
- R2: A `start` seen at a clock edge while idle makes `busy` 1 from that edge on, and `dac_code` holds only its most significant bit set (mid-scale) for the first trial cycle.
- R3: At the edge that ends a trial cycle, the bit under test stays 1 when `cmp_above` is 1 and is cleared when `cmp_above` is 0. No other decided bit changes.
- R4: The same edge sets the next lower bit of `dac_code` as the new trial bit, so each trial code equals the decided upper bits followed by a single 1.
- R5: `busy` stays high for exactly WIDTH cycles. `done` rises at the WIDTH-th edge after the start edge, for every input value.
- R6: With an ideal comparator whose analog level sits half an LSB above integer value V (so `cmp_above` = V >= `dac_code`), `result` equals V.
- R7: A `start` asserted while `busy` is 1 has no effect: conversion length and result are unchanged, and no new conversion follows.
- R8: `done` drops to 0 at the edge that launches a new conversion and stays 0 until that conversion completes.
- R9: `result` keeps the previous conversion's value until the edge at which the next conversion completes.
- R10: For WIDTH = 6, the comparator sequence 1,0,0,1,1,0 gives trial codes 100000, 110000, 101000, 100100, 100110, 100111 and a final `result` of 100110.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Conversion request, honoured only while idle |
| cmp_above | input | 1 | Comparator: analog input above DAC level |
| dac_code | output | WIDTH | Trial code driven to the DAC |
| busy | output | 1 | High during the WIDTH trial cycles |
| result | output | WIDTH | Last completed conversion code |
| done | output | 1 | Conversion-complete flag |

## Verification
The checker watches several properties on every cycle. A launch must place the mid-scale code on the DAC port. Each step may set at most one new code bit. Every conversion must last exactly WIDTH busy cycles, ending with `done` high. The reported result may change only on a completion edge. The bench scenarios are needed for the rest: the final code matching the modelled analog input across many values, the six-bit keep/clear trace, a start request landing mid-conversion being ignored, and a reset cutting a conversion short.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic {
    SAR_IDLE    = 1'b0,
    SAR_CONVERT = 1'b1
  } sar_state_t;
endpackage

// File: rtl/sar_bit_walker.sv
// One-hot pointer to the bit under test; walks from MSB to LSB.
module sar_bit_walker #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             launch,
  input  logic             advance,
  output logic [WIDTH-1:0] ptr,
  output logic             last
);
  localparam logic [WIDTH-1:0] MSB_ONLY = {1'b1, {(WIDTH-1){1'b0}}};

  always_ff @(posedge clk) begin
    if (rst)          ptr <= '0;
    else if (launch)  ptr <= MSB_ONLY;
    else if (advance) ptr <= ptr >> 1;
  end

  assign last = ptr[0];
endmodule

// File: rtl/sar_trial_reg.sv
// Trial code register: keeps or drops the tested bit, then sets the next one.
module sar_trial_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             launch,
  input  logic             advance,
  input  logic [WIDTH-1:0] ptr,
  input  logic             cmp_above,
  output logic [WIDTH-1:0] code,
  output logic [WIDTH-1:0] decided
);
  localparam logic [WIDTH-1:0] MSB_ONLY = {1'b1, {(WIDTH-1){1'b0}}};

  assign decided = cmp_above ? code : (code & ~ptr);

  always_ff @(posedge clk) begin
    if (rst)          code <= '0;
    else if (launch)  code <= MSB_ONLY;
    else if (advance) code <= decided | (ptr >> 1);
  end
endmodule

// File: rtl/sar_result_hold.sv
// Holds the last finished code and the completion flag.
module sar_result_hold #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             launch,
  input  logic             finish,
  input  logic [WIDTH-1:0] final_code,
  output logic [WIDTH-1:0] result,
  output logic             done
);
  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      done   <= 1'b0;
    end else if (finish) begin
      result <= final_code;
      done   <= 1'b1;
    end else if (launch) begin
      done   <= 1'b0;
    end
  end
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             cmp_above,
  output logic [WIDTH-1:0] dac_code,
  output logic             busy,
  output logic [WIDTH-1:0] result,
  output logic             done
);
  import sar_pkg::*;

  sar_state_t       state;
  logic             launch, advance, finish, last;
  logic [WIDTH-1:0] ptr, decided;

  assign launch  = (state == SAR_IDLE) && start;
  assign advance = (state == SAR_CONVERT);
  assign finish  = advance && last;

  always_ff @(posedge clk) begin
    if (rst)         state <= SAR_IDLE;
    else if (launch) state <= SAR_CONVERT;
    else if (finish) state <= SAR_IDLE;
  end

  assign busy = (state == SAR_CONVERT);

  sar_bit_walker #(.WIDTH(WIDTH)) u_walker (
    .clk(clk), .rst(rst), .launch(launch), .advance(advance),
    .ptr(ptr), .last(last)
  );

  sar_trial_reg #(.WIDTH(WIDTH)) u_trial (
    .clk(clk), .rst(rst), .launch(launch), .advance(advance),
    .ptr(ptr), .cmp_above(cmp_above), .code(dac_code), .decided(decided)
  );

  sar_result_hold #(.WIDTH(WIDTH)) u_hold (
    .clk(clk), .rst(rst), .launch(launch), .finish(finish),
    .final_code(decided), .result(result), .done(done)
  );
endmodule

// File: rtl/sar_conv_ctrl_chk.sv
module sar_conv_ctrl_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [WIDTH-1:0] dac_code,
  input logic             busy,
  input logic [WIDTH-1:0] result,
  input logic             done
);
  localparam int CW = $clog2(WIDTH + 2);
  localparam logic [WIDTH-1:0] MSB_ONLY = {1'b1, {(WIDTH-1){1'b0}}};

  logic [CW-1:0] busy_cnt;
  always_ff @(posedge clk) begin
    if (rst)       busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + 1'b1;
    else           busy_cnt <= '0;
  end

  // R2: launch from idle puts mid-scale on the DAC
  p_launch_midscale_r2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && dac_code == MSB_ONLY));

  // R3, R4: a step never sets more than one new code bit
  p_one_new_bit_r4: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ($countones(dac_code & ~$past(dac_code)) <= 1));

  // R5, R7: busy lasts exactly WIDTH cycles, then done is high
  p_fixed_length_r5: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && !$past(rst)) |-> (busy_cnt == CW'(WIDTH) && done));

  // R8: done and busy are never high together
  p_done_clear_r8: assert property (@(posedge clk) disable iff (rst)
    !(done && busy));

  // R9: result only moves on a completion edge
  p_result_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$fell(busy)) |-> $stable(result));
endmodule

bind sar_conv_ctrl sar_conv_ctrl_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .start(start), .dac_code(dac_code),
  .busy(busy), .result(result), .done(done)
);

// File: tb/tb_sar_conv_ctrl.sv
module tb_sar_conv_ctrl;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic cmp_above;
  logic [N-1:0] dac_code, result;
  logic busy, done;
  int vin = 0;

  logic start6 = 1'b0;
  logic cmp6 = 1'b0;
  logic [5:0] dac6, result6;
  logic busy6, done6;

  int n_checks = 0;
  int n_errors = 0;
  bit timed_out = 1'b0;

  always #4 clk = ~clk;

  // ideal comparator, analog level half an LSB above vin
  assign cmp_above = (vin >= int'(dac_code));

  sar_conv_ctrl #(.WIDTH(N)) dut (
    .clk(clk), .rst(rst), .start(start), .cmp_above(cmp_above),
    .dac_code(dac_code), .busy(busy), .result(result), .done(done)
  );

  sar_conv_ctrl #(.WIDTH(6)) u_six (
    .clk(clk), .rst(rst), .start(start6), .cmp_above(cmp6),
    .dac_code(dac6), .busy(busy6), .result(result6), .done(done6)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Launch at a negedge; returns cycles until done and checks result.
  task automatic convert(input int v, input int mid_start_at);
    int cycles;
    vin = v;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2 busy after launch", busy, 1);
    check("R2 midscale trial", dac_code, 1 << (N-1));
    check("R8 done cleared at launch", done, 0);
    cycles = 0;
    while (!done && cycles < 4*N) begin
      if (cycles == mid_start_at) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cycles++;
    end
    check("R5 fixed length", cycles, N);
    check("R6 result equals input", result, v);
  endtask

  task automatic t_reset;
    check("R1 dac_code reset", dac_code, 0);
    check("R1 result reset", result, 0);
    check("R1 done reset", done, 0);
    check("R1 busy reset", busy, 0);
  endtask

  task automatic t_values;
    int vals[8] = '{0, 255, 128, 127, 1, 85, 170, 200};
    foreach (vals[i]) convert(vals[i], -1);
  endtask

  task automatic t_start_ignored;
    convert(99, 3);
    @(negedge clk);
    check("R7 no relaunch after mid start", busy, 0);
    check("R7 result kept", result, 99);
    convert(42, N-1);
    @(negedge clk);
    check("R7 no relaunch after late start", busy, 0);
  endtask

  task automatic t_hold;
    bit moved = 1'b0;
    int cycles = 0;
    convert(60, -1);
    vin = 201;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R8 done low after new start", done, 0);
    while (!done && cycles < 4*N) begin
      if (result != 60) moved = 1'b1;
      @(negedge clk);
      cycles++;
    end
    check("R9 result held during next conversion", moved, 0);
    check("R9 result updated at completion", result, 201);
  endtask

  task automatic t_six;
    bit pat[6] = '{1, 0, 0, 1, 1, 0};
    int exp_trial[6] = '{6'b100000, 6'b110000, 6'b101000, 6'b100100, 6'b100110, 6'b100111};
    start6 = 1'b1;
    @(negedge clk);
    start6 = 1'b0;
    for (int k = 0; k < 6; k++) begin
      check("R3 R4 R10 trial code", dac6, exp_trial[k]);
      check("R10 not done yet", done6, 0);
      cmp6 = pat[k];
      @(negedge clk);
    end
    check("R10 done", done6, 1);
    check("R10 final code 100110", result6, 6'b100110);
  endtask

  task automatic t_reset_mid;
    vin = 77;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    convert(77, -1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_values();
    t_start_ignored();
    t_hold();
    t_six();
    t_reset_mid();
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_errors++;
    timed_out = 1'b1;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule